// File: doc/BRIEF.md
# Bipolar Line Receive Decoder (AMI / HDB3 / NRZ)

This block turns a dual-rail bipolar receive stream into a single-rail NRZ bit stream. Each clock period carries one symbol: a mark on the positive rail, a mark on the negative rail, a space, or an illegal mark on both rails. The decoder applies alternate-mark-inversion rules or HDB3 rules. Under HDB3 it removes the zero-substitution codes. It flags every line code violation with a one-cycle strobe and accumulates the violations in a saturating counter. A third mode bypasses the decoder for a plain NRZ input. That input is taken from the positive rail on the falling clock edge, and no error is reported in this mode.

All decoded data passes through a fixed delay line, so a substitution code can be erased after it is recognised at its last symbol. The output latency is the same in every mode. The block expects the recovered clock and the sliced rail levels from the front end. It delivers data, the violation strobe and the running count to the framing logic.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: In AMI mode (`line_mode` = 2'b00) a mark on either rail decodes to 1 and a space to 0. The symbol sampled at rising edge n drives `dec_data` from rising edge n+3 until edge n+4.
- R2: In AMI mode, a single-rail mark with the same polarity as the previous single-rail mark raises `cv_strobe` for exactly the cycle after the edge that sampled it.
- R3: In HDB3 mode (`line_mode` = 2'b01), a same-polarity mark that follows three spaces is a substitution code and decodes to four zeros.
- R4: In HDB3 mode, a same-polarity mark that follows two spaces and a mark is a substitution code, and both of those marks decode to zeros.
- R5: In HDB3 mode, a same-polarity mark whose polarity matches the previous same-polarity mark raises `cv_strobe`. Same-polarity marks that alternate in polarity raise nothing.
- R6: In HDB3 mode with `ext_check` = 1, the fourth consecutive space of a run raises `cv_strobe` once for that run. With `ext_check` = 0, runs of spaces are not flagged.
- R7: In AMI or HDB3 mode, a mark on both rails at once decodes to 1 and raises `cv_strobe`.
- R8: In NRZ mode (`line_mode` = 2'b10 or 2'b11), `dec_data` carries `rail_pos` as sampled on the falling clock edge, with the latency of R1. In this mode `cv_strobe` stays 0 and `cv_count` does not advance.
- R9: `cv_count` advances by one on the same edge that sets `cv_strobe`, and it changes at no other time except a clear.
- R10: `cv_count` holds at 16'hFFFF once it reaches that value.
- R11: `cnt_clear` high at an edge sets `cv_count` to 0. If a violation is sampled at the same edge, `cv_count` becomes 1.
- R12: After a synchronous reset, `dec_data`, `cv_strobe` and `cv_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered receive clock, one symbol per period |
| rst | input | 1 | Synchronous active-high reset |
| rail_pos | input | 1 | Positive-rail mark, or NRZ data in bypass mode |
| rail_neg | input | 1 | Negative-rail mark |
| line_mode | input | 2 | 00 AMI, 01 HDB3, 1x NRZ bypass |
| ext_check | input | 1 | HDB3 only: also flag runs of four spaces |
| cnt_clear | input | 1 | Synchronous clear of the violation count |
| dec_data | output | 1 | Decoded NRZ data, delayed by the fixed latency |
| cv_strobe | output | 1 | One-cycle pulse per detected code violation |
| cv_count | output | 16 | Saturating code violation count |

## Verification
The bound checker tests the counter rules on every cycle. The count steps by at most one, tracks the strobe, holds at full scale and drops to 0 or 1 on a clear. It also checks that bypass mode stays silent and that a mark on both rails is flagged. Only the bench can show the sequence-dependent behaviour: the polarity history, the erasure of both substitution codes in the delayed data, the double-violation rule, and the space-run rule with and without the extended enable. The bench shows these by comparing the outputs every cycle with a behavioural model over directed patterns and pseudo-random streams.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  typedef enum logic [1:0] {
    LC_AMI   = 2'b00,
    LC_HDB3  = 2'b01,
    LC_NRZ   = 2'b10,
    LC_NRZ_B = 2'b11
  } line_code_e;

  typedef struct packed {
    logic pos;
    logic neg;
  } rail_sym_t;

  typedef struct packed {
    logic mark;    // any mark on the line this symbol
    logic cv;      // code violation detected on this symbol
    logic zero_v;  // symbol is the closing mark of a substitution code
    logic clr_b;   // the leading mark of a B00V code must be erased
  } det_out_t;

endpackage

// File: rtl/hdb3_rx_nrz_sample.sv
module hdb3_rx_nrz_sample (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  // NRZ data is taken on the falling edge of the receive clock
  always_ff @(negedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= din;
  end
endmodule

// File: rtl/hdb3_rx_violation.sv
module hdb3_rx_violation
  import hdb3_rx_pkg::*;
#(
  parameter int SUB_LEN    = 4,  // length of a substitution code in symbols
  parameter int ZRUN_LIMIT = 4   // space run length flagged by extended check
) (
  input  logic       clk,
  input  logic       rst,
  input  rail_sym_t  sym,
  input  line_code_e mode,
  input  logic       ext_en,
  output det_out_t   det
);
  localparam int HIST = SUB_LEN - 1;
  localparam int ZW   = $clog2(ZRUN_LIMIT + 1);
  localparam logic [ZW-1:0] ZHIT = ZW'(ZRUN_LIMIT - 1);
  localparam logic [ZW-1:0] ZTOP = ZW'(ZRUN_LIMIT);

  logic            have_mark, mark_neg;
  logic            have_v, v_neg;
  logic [HIST-1:0] raw_hist;   // [0] is the most recent symbol
  logic [ZW-1:0]   zrun;

  logic is_ami, is_hdb, bipolar;
  logic single, dual, mark, s_neg, same_pol;
  logic ami_cv, dv_cv, zero_cv, dual_cv;
  logic gap_clear;

  always_comb begin
    is_ami   = (mode == LC_AMI);
    is_hdb   = (mode == LC_HDB3);
    bipolar  = is_ami | is_hdb;
    single   = sym.pos ^ sym.neg;
    dual     = sym.pos & sym.neg;
    mark     = sym.pos | sym.neg;
    s_neg    = sym.neg;
    same_pol = single & have_mark & (s_neg == mark_neg);

    ami_cv   = is_ami & same_pol;
    dv_cv    = is_hdb & same_pol & have_v & (s_neg == v_neg);
    zero_cv  = is_hdb & ext_en & ~mark & (zrun == ZHIT);
    dual_cv  = bipolar & dual;

    gap_clear = (raw_hist[HIST-2:0] == '0);

    det.mark   = mark;
    det.cv     = ami_cv | dv_cv | zero_cv | dual_cv;
    det.zero_v = is_hdb & same_pol & gap_clear;
    det.clr_b  = is_hdb & same_pol & gap_clear & raw_hist[HIST-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_mark <= 1'b0;
      mark_neg  <= 1'b0;
      have_v    <= 1'b0;
      v_neg     <= 1'b0;
      raw_hist  <= '0;
      zrun      <= '0;
    end else if (bipolar) begin
      raw_hist <= {raw_hist[HIST-2:0], mark};
      if (mark)              zrun <= '0;
      else if (zrun != ZTOP) zrun <= zrun + 1'b1;
      if (single) begin
        have_mark <= 1'b1;
        mark_neg  <= s_neg;
      end
      if (is_hdb && same_pol) begin
        have_v <= 1'b1;
        v_neg  <= s_neg;
      end
    end
  end
endmodule

// File: rtl/hdb3_rx_delay_line.sv
module hdb3_rx_delay_line #(
  parameter int DEPTH     = 4,
  parameter int CLR_STAGE = 3   // stage loaded with 0 when clr_tap is high
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  input  logic clr_tap,
  output logic dout
);
  logic stg [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= 1'b0;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    if (g == CLR_STAGE) begin : g_clr
      always_ff @(posedge clk) begin
        if (rst || clr_tap) stg[g] <= 1'b0;
        else                stg[g] <= stg[g-1];
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= 1'b0;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/hdb3_rx_err_counter.sv
module hdb3_rx_err_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (clr)                cnt <= W'(inc);
    else if (inc && cnt != FULL) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int SUB_LEN    = 4,
  parameter int ZRUN_LIMIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rail_pos,
  input  logic             rail_neg,
  input  logic [1:0]       line_mode,
  input  logic             ext_check,
  input  logic             cnt_clear,
  output logic             dec_data,
  output logic             cv_strobe,
  output logic [CNT_W-1:0] cv_count
);
  localparam int DEPTH = SUB_LEN;

  line_code_e mode_q;
  rail_sym_t  sym;
  det_out_t   det;
  logic       nrz_bit, line_bit, bypass;

  always_comb begin
    mode_q   = line_code_e'(line_mode);
    sym.pos  = rail_pos;
    sym.neg  = rail_neg;
    bypass   = line_mode[1];
    line_bit = bypass ? nrz_bit : (det.mark & ~det.zero_v);
  end

  hdb3_rx_nrz_sample u_nrz (
    .clk (clk),
    .rst (rst),
    .din (rail_pos),
    .q   (nrz_bit)
  );

  hdb3_rx_violation #(
    .SUB_LEN    (SUB_LEN),
    .ZRUN_LIMIT (ZRUN_LIMIT)
  ) u_det (
    .clk    (clk),
    .rst    (rst),
    .sym    (sym),
    .mode   (mode_q),
    .ext_en (ext_check),
    .det    (det)
  );

  hdb3_rx_delay_line #(
    .DEPTH     (DEPTH),
    .CLR_STAGE (SUB_LEN - 1)
  ) u_dly (
    .clk     (clk),
    .rst     (rst),
    .din     (line_bit),
    .clr_tap (det.clr_b),
    .dout    (dec_data)
  );

  hdb3_rx_err_counter #(
    .W (CNT_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clear),
    .inc (det.cv),
    .cnt (cv_count)
  );

  always_ff @(posedge clk) begin
    if (rst) cv_strobe <= 1'b0;
    else     cv_strobe <= det.cv;
  end
endmodule

// File: rtl/hdb3_rx_decoder_chk.sv
module hdb3_rx_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rail_pos,
  input logic             rail_neg,
  input logic [1:0]       line_mode,
  input logic             cnt_clear,
  input logic             cv_strobe,
  input logic [CNT_W-1:0] cv_count
);
  localparam logic [CNT_W-1:0] FULL = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  AST_BYPASS_SILENT: assert property (@(posedge clk) disable iff (rst)
    line_mode[1] |=> !cv_strobe);  // R8

  AST_BYPASS_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (line_mode[1] && !cnt_clear) |=> $stable(cv_count));  // R8

  AST_DUAL_RAIL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!line_mode[1] && rail_pos && rail_neg) |=> cv_strobe);  // R7

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !cnt_clear |=> (cv_count == $past(cv_count) || cv_count == $past(cv_count) + ONE));  // R9

  AST_CNT_TRACKS_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clear && cv_count != FULL) |=> (cv_strobe == (cv_count != $past(cv_count))));  // R9

  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (!cnt_clear && cv_count == FULL) |=> (cv_count == FULL));  // R10

  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cnt_clear |=> (cv_count == (cv_strobe ? ONE : '0)));  // R11
endmodule

bind hdb3_rx_decoder hdb3_rx_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rail_pos  (rail_pos),
  .rail_neg  (rail_neg),
  .line_mode (line_mode),
  .cnt_clear (cnt_clear),
  .cv_strobe (cv_strobe),
  .cv_count  (cv_count)
);

// File: tb/sim_hdb3_rx_decoder.sv
module sim_hdb3_rx_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rail_pos = 1'b0, rail_neg = 1'b0;
  logic [1:0]  line_mode = 2'b00;
  logic        ext_check = 1'b0;
  logic        cnt_clear = 1'b0;
  logic        dec_data, cv_strobe;
  logic [15:0] cv_count;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R12";
  bit    done = 0;

  always #5 clk = ~clk;

  hdb3_rx_decoder u0 (
    .clk(clk), .rst(rst), .rail_pos(rail_pos), .rail_neg(rail_neg),
    .line_mode(line_mode), .ext_check(ext_check), .cnt_clear(cnt_clear),
    .dec_data(dec_data), .cv_strobe(cv_strobe), .cv_count(cv_count)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int last_pol = 0, v_pol = 0, zrun = 0;
  bit raw0 = 0, raw1 = 0, raw2 = 0;
  bit hist[$];
  int m_cnt = 0;
  bit m_viol = 0;
  bit model_ok = 0;

  always @(posedge clk) begin
    bit mark, dual, single, b, cv, erase_b, same;
    int pol;
    mark = rail_pos | rail_neg; dual = rail_pos & rail_neg; single = rail_pos ^ rail_neg;
    pol = rail_pos ? 1 : -1;
    cv = 0; erase_b = 0;
    if (rst) begin
      last_pol = 0; v_pol = 0; zrun = 0; raw0 = 0; raw1 = 0; raw2 = 0;
      hist = {0, 0, 0, 0}; m_cnt = 0; m_viol = 0;
    end else begin
      if (line_mode >= 2) b = rail_pos;
      else begin
        same = single && last_pol != 0 && pol == last_pol;
        b = mark;
        if (dual) cv = 1;
        if (line_mode == 0 && same) cv = 1;
        if (line_mode == 1) begin
          if (same && v_pol != 0 && pol == v_pol) cv = 1;
          if (ext_check && !mark && zrun == 3) cv = 1;
          if (same && !raw0 && !raw1) begin b = 0; erase_b = raw2; end
          if (same) v_pol = pol;
        end
        zrun = mark ? 0 : (zrun < 4 ? zrun + 1 : zrun);
        raw2 = raw1; raw1 = raw0; raw0 = mark;
        if (single) last_pol = pol;
      end
      hist.push_back(b);
      void'(hist.pop_front());
      if (erase_b) hist[0] = 0;
      if (cnt_clear) m_cnt = cv ? 1 : 0;
      else if (cv && m_cnt < 65535) m_cnt++;
      m_viol = cv;
    end
    model_ok = 1;
    #1;
    if (!done) begin
      chk(cur_req, "dec_data", int'(dec_data), int'(hist[0]));
      chk(cur_req, "cv_strobe", int'(cv_strobe), int'(m_viol));
      chk(cur_req, "cv_count", int'(cv_count), m_cnt);
    end
  end

  // ---------------- stimulus ----------------
  // v: 0 space, 1 positive mark, -1 negative mark, 2 both rails
  task automatic sym(input int v);
    @(posedge clk); #2;
    rail_pos = (v == 1 || v == 2);
    rail_neg = (v == -1 || v == 2);
  endtask

  task automatic cfg(input logic [1:0] m, input logic e);
    @(posedge clk); #2;
    line_mode = m; ext_check = e; rail_pos = 0; rail_neg = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #2; rst = 1;
    repeat (2) @(posedge clk);
    #2 rst = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) sym(0);
  endtask

  initial begin
    int ones;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12", "reset dec_data", int'(dec_data), 0);
    chk("R12", "reset cv_strobe", int'(cv_strobe), 0);
    chk("R12", "reset cv_count", int'(cv_count), 0);
    #2 rst = 0;

    // AMI decoding and bipolar violations
    cur_req = "R1"; cfg(2'b00, 0);
    sym(1); sym(0); sym(-1); sym(1); sym(0); sym(0); sym(-1); idle(4);
    cur_req = "R2";
    sym(1); sym(1); sym(-1); sym(-1); sym(0); sym(1); idle(5);

    // HDB3: 000V, B00V with alternating V, then a double violation
    do_reset();
    cur_req = "R3"; cfg(2'b01, 0);
    sym(1); sym(0); sym(0); sym(0); sym(1); idle(1);
    cur_req = "R4";
    sym(-1); sym(1); sym(-1); sym(0); sym(0); sym(-1); idle(5);
    cur_req = "R5";
    sym(1); sym(0); sym(0); sym(0); sym(1);
    sym(0); sym(0); sym(0); sym(1); idle(5);

    // Directed check: a pure substitution stream decodes to all zeros
    cur_req = "R3";
    sym(-1); idle(4);
    ones = 0;
    fork
      begin for (int i = 0; i < 4; i++) sym(0); sym(-1); idle(4); end
      begin
        @(posedge clk); @(posedge clk);
        for (int i = 0; i < 8; i++) begin @(negedge clk); ones += int'(dec_data); end
      end
    join
    chk("R3", "ones in 000V window", ones, 0);

    // Extended check on and off
    do_reset();
    cur_req = "R6"; cfg(2'b01, 1);
    sym(1); idle(6); sym(-1); idle(3); sym(1); idle(4);
    cfg(2'b01, 0);
    sym(-1); idle(7); sym(1); idle(4);

    // Dual-rail marks in both bipolar modes
    cur_req = "R7"; cfg(2'b00, 0);
    sym(2); sym(1); sym(2); sym(-1); idle(4);
    cfg(2'b01, 1);
    sym(2); sym(0); sym(2); idle(4);

    // NRZ bypass with junk on the negative rail
    cur_req = "R8"; cfg(2'b10, 1);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); #2;
      rail_pos = $urandom_range(0, 1); rail_neg = $urandom_range(0, 1);
    end
    cfg(2'b11, 0);
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #2;
      rail_pos = $urandom_range(0, 1); rail_neg = 1;
    end

    // Pseudo-random bipolar streams
    cur_req = "R9"; cfg(2'b01, 1);
    for (int i = 0; i < 400; i++) sym($urandom_range(0, 3) == 3 ? 0 : ($urandom_range(0, 1) ? 1 : -1));
    cfg(2'b00, 0);
    for (int i = 0; i < 300; i++) sym(int'($urandom_range(0, 3)) - 1);
    cfg(2'b01, 0);
    for (int i = 0; i < 300; i++) sym(int'($urandom_range(0, 3)) - 1);

    // Clear with and without a simultaneous violation
    cur_req = "R11"; cfg(2'b00, 0);
    sym(2); sym(2);
    @(posedge clk); #2; rail_pos = 1; rail_neg = 1; cnt_clear = 1;
    @(posedge clk); #2; rail_pos = 0; rail_neg = 0; cnt_clear = 0;
    @(negedge clk);
    chk("R11", "clear with violation", int'(cv_count), 1);
    @(posedge clk); #2; cnt_clear = 1;
    @(posedge clk); #2; cnt_clear = 0;
    @(negedge clk);
    chk("R11", "clear alone", int'(cv_count), 0);

    // Saturation
    cur_req = "R10";
    for (int i = 0; i < 65540; i++) sym(2);
    sym(0);
    @(negedge clk);
    chk("R10", "saturated count", int'(cv_count), 16'hFFFF);
    @(posedge clk); #2; cnt_clear = 1;
    @(posedge clk); #2; cnt_clear = 0;
    @(negedge clk);
    chk("R11", "clear after saturation", int'(cv_count), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 10);
    n_fail++;
    $display("FAIL watchdog R12 actual=hung expected=finished");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule